// File: doc/BRIEF.md
# UART Modem Control and Status

This block is the modem-handshake section of one serial channel in a 16550-style UART. Software reaches it through a small register port. A control register drives the active-low terminal-ready output and a general-purpose output pin. The same register decides whether the channel interrupt line is driven or left floating. Floating is modelled here with an output-enable signal.

A status register reports the four active-low modem inputs: clear-to-send, data-set-ready, ring and carrier-detect. Each input passes through a two-flop synchroniser. A change on an input latches a sticky change flag. When modem-status interrupts are enabled, any set change flag raises an interrupt request. A feature register holds the flag that lets clear-to-send stall the transmitter.

Register map (2-bit address): 0 = control (read/write), 1 = status (read, clears on read), 2 = feature (read/write, only bit 7 is stored), 3 = reads zero.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, `dtr_n` and `op_n` are 1, `irq_oe` is 0, `msi_req` is 0, and the control and status registers read 0x00 while all modem inputs are high.
- R2: One cycle after a write to address 0, `dtr_n` equals the complement of written bit 0. The control register reads back the written byte.
- R3: Control bit 3 set gives `irq_oe`=1 and `op_n`=0. Control bit 3 clear gives `irq_oe`=0 and `op_n`=1.
- R4: Status bits 4, 5, 6 and 7 are the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, in that order. Each bit follows its pin after two clock edges.
- R5: Status bits 0, 1 and 3 latch any change of `cts_n`, `dsr_n` and `dcd_n` respectively. Each bit is set on the third clock edge after the pin changes.
- R6: Status bit 2 is set only when `ri_n` goes from low to high. A high-to-low change of `ri_n` leaves it clear.
- R7: A read of address 1 returns the current status value, and bits 3..0 are cleared on that clock edge. A change that lands on the same edge as the read stays set.
- R8: `msi_req` is high exactly when `ms_irq_en` is 1 and any of status bits 3..0 is set. `irq_pin` is `chan_irq` OR `msi_req`.
- R9: Bit 7 of the feature register enables automatic flow control. While that bit is set, `tx_allow` follows the synchronised clear-to-send input being asserted. While it is clear, `tx_allow` stays 1.
- R10: A write to address 1 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| op_n | output | 1 | User output pin |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| chan_irq | input | 1 | Interrupt from the other channel sources |
| msi_req | output | 1 | Modem-status interrupt request |
| irq_pin | output | 1 | Channel interrupt level |
| irq_oe | output | 1 | Interrupt pin driver enable |
| tx_allow | output | 1 | Transmitter may start a character |

## Verification
A wrong change flag shows at the ports in two ways: through `msi_req` once modem interrupts are enabled, and through the status read value on the next peek. In both cases it appears on the third edge after the pin moves. Synchroniser latency errors appear as status bits that flip one edge early or late. Errors in the read-clear path appear as flags that survive a read, or as a same-edge change that is lost. Control-register faults reach `dtr_n`, `op_n` and `irq_oe` one edge after the write.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       op_n,
  input  logic       ms_irq_en,
  input  logic       chan_irq,
  output logic       msi_req,
  output logic       irq_pin,
  output logic       irq_oe,
  output logic       tx_allow
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_STA = 2'd1;
  localparam logic [1:0] A_FEA = 2'd2;

  logic [7:0] ctl_q;
  logic       auto_cts;
  logic [3:0] s1, s2, prev;
  logic [3:0] delta;
  logic [3:0] evt;
  logic       rd_clr;

  // bit order {dcd, ri, dsr, cts}
  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 4'hF;
      s2   <= 4'hF;
      prev <= 4'hF;
    end else begin
      s1   <= {dcd_n, ri_n, dsr_n, cts_n};
      s2   <= s1;
      prev <= s2;
    end
  end

  assign evt = {s2[3] ^ prev[3], s2[2] & ~prev[2], s2[1] ^ prev[1], s2[0] ^ prev[0]};
  assign rd_clr = rd_en && (addr == A_STA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= 8'h00;
      auto_cts <= 1'b0;
      delta    <= 4'h0;
    end else begin
      if (wr_en && addr == A_CTL) ctl_q <= wdata;
      if (wr_en && addr == A_FEA) auto_cts <= wdata[7];
      delta <= (rd_clr ? 4'h0 : delta) | evt;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = ctl_q;
      A_STA:   rdata = {~s2, delta};
      A_FEA:   rdata = {auto_cts, 7'b0};
      default: rdata = 8'h00;
    endcase
  end

  assign dtr_n    = ~ctl_q[0];
  assign op_n     = ~ctl_q[3];
  assign irq_oe   = ctl_q[3];
  assign msi_req  = ms_irq_en & (|delta);
  assign irq_pin  = chan_irq | msi_req;
  assign tx_allow = ~auto_cts | ~s2[0];
endmodule

module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       dtr_n,
  input logic       op_n,
  input logic       irq_oe,
  input logic       ms_irq_en,
  input logic       msi_req,
  input logic       tx_allow,
  input logic       auto_cts,
  input logic [3:0] delta,
  input logic       ri_sync
);
  AST_DTR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> (dtr_n == !$past(wdata[0]))); // R2
  AST_OP_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
    irq_oe == !op_n); // R3
  AST_RI_TRAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(delta[2]) |-> $past(ri_sync)); // R6
  AST_DELTA_CLEAR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(|delta) |-> $past(rd_en && addr == 2'd1)); // R7
  AST_MSI_GATED: assert property (@(posedge clk) disable iff (rst)
    !ms_irq_en |-> !msi_req); // R8
  AST_TX_STALL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !tx_allow |-> auto_cts); // R9
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .dtr_n(dtr_n), .op_n(op_n), .irq_oe(irq_oe),
  .ms_irq_en(ms_irq_en), .msi_req(msi_req), .tx_allow(tx_allow),
  .auto_cts(auto_cts), .delta(delta), .ri_sync(s2[2])
);

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       dtr_n, op_n, msi_req, irq_pin, irq_oe, tx_allow;
  logic       ms_irq_en = 1'b0, chan_irq = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_modem_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
    .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .op_n(op_n),
    .ms_irq_en(ms_irq_en), .chan_irq(chan_irq), .msi_req(msi_req),
    .irq_pin(irq_pin), .irq_oe(irq_oe), .tx_allow(tx_allow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 dtr_n", {7'b0, dtr_n}, 8'h01);
    check("R1 op_n", {7'b0, op_n}, 8'h01);
    check("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
    check("R1 msi_req", {7'b0, msi_req}, 8'h00);
    peek(2'd0, v); check("R1 ctl", v, 8'h00);
    peek(2'd1, v); check("R1 status", v, 8'h00);
  endtask

  task automatic t_ctl;
    logic [7:0] v;
    reg_wr(2'd0, 8'h01);
    check("R2 dtr asserted", {7'b0, dtr_n}, 8'h00);
    check("R3 op idle", {7'b0, op_n}, 8'h01);
    peek(2'd0, v); check("R2 readback", v, 8'h01);
    reg_wr(2'd0, 8'h08);
    check("R2 dtr released", {7'b0, dtr_n}, 8'h01);
    check("R3 op low", {7'b0, op_n}, 8'h00);
    check("R3 oe on", {7'b0, irq_oe}, 8'h01);
    reg_wr(2'd0, 8'h00);
    check("R3 oe off", {7'b0, irq_oe}, 8'h00);
    check("R3 op high", {7'b0, op_n}, 8'h01);
  endtask

  task automatic t_cts;
    logic [7:0] v;
    cts_n = 1'b0;
    tick(1); peek(2'd1, v); check("R4 one edge", v, 8'h00);
    tick(1); peek(2'd1, v); check("R4 cts status", v, 8'h10);
    tick(1); peek(2'd1, v); check("R5 cts delta", v, 8'h11);
    check("R8 masked", {7'b0, msi_req}, 8'h00);
    ms_irq_en = 1'b1; #1;
    check("R8 msi on", {7'b0, msi_req}, 8'h01);
    check("R8 irq pin", {7'b0, irq_pin}, 8'h01);
    reg_rd(2'd1, v); check("R7 read value", v, 8'h11);
    peek(2'd1, v); check("R7 cleared", v, 8'h10);
    check("R7 msi cleared", {7'b0, msi_req}, 8'h00);
    chan_irq = 1'b1; #1;
    check("R8 chan irq pass", {7'b0, irq_pin}, 8'h01);
    chan_irq = 1'b0;
    cts_n = 1'b1; tick(3);
    reg_rd(2'd1, v); check("R5 cts release delta", v, 8'h01);
  endtask

  task automatic t_ri;
    logic [7:0] v;
    ri_n = 1'b0; tick(4);
    peek(2'd1, v); check("R6 falling ignored", v, 8'h40);
    check("R6 no msi", {7'b0, msi_req}, 8'h00);
    ri_n = 1'b1; tick(2);
    peek(2'd1, v); check("R6 not yet", v, 8'h00);
    tick(1);
    peek(2'd1, v); check("R6 trailing edge", v, 8'h04);
    reg_rd(2'd1, v);
  endtask

  task automatic t_dsr_dcd;
    logic [7:0] v;
    dsr_n = 1'b0; dcd_n = 1'b0; tick(3);
    peek(2'd1, v); check("R5 dsr dcd", v, 8'hAA);
    reg_rd(2'd1, v);
    peek(2'd1, v); check("R7 clear dsr dcd", v, 8'hA0);
  endtask

  task automatic t_same_edge;
    logic [7:0] v;
    dcd_n = 1'b1; tick(3);
    dsr_n = 1'b1; tick(2);
    reg_rd(2'd1, v); check("R7 read before merge", v, 8'h08);
    peek(2'd1, v); check("R7 same-edge kept", v, 8'h02);
    reg_rd(2'd1, v);
  endtask

  task automatic t_msr_write;
    logic [7:0] v;
    peek(2'd1, v); check("R10 before", v, 8'h00);
    reg_wr(2'd1, 8'hFF);
    peek(2'd1, v); check("R10 write ignored", v, 8'h00);
  endtask

  task automatic t_autocts;
    logic [7:0] v;
    check("R9 default allow", {7'b0, tx_allow}, 8'h01);
    reg_wr(2'd2, 8'h80);
    peek(2'd2, v); check("R9 flag read", v, 8'h80);
    check("R9 stalled", {7'b0, tx_allow}, 8'h00);
    cts_n = 1'b0; tick(1);
    check("R9 sync delay", {7'b0, tx_allow}, 8'h00);
    tick(1);
    check("R9 allowed", {7'b0, tx_allow}, 8'h01);
    cts_n = 1'b1; tick(2);
    reg_wr(2'd2, 8'h00);
    check("R9 flag off", {7'b0, tx_allow}, 8'h01);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset;
    t_ctl;
    t_cts;
    t_ri;
    t_dsr_dcd;
    t_same_edge;
    t_msr_write;
    t_autocts;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule